// File: doc/BRIEF.md
# Branch Event Address Tracker

This block holds one 64-bit register with the address of the last instruction that broke sequential execution. It watches the retire stream. When a taken branch completes, the register is loaded with that branch's address. If the branch ran as the target of an execute-type instruction, the register is loaded with the executor's address instead. Instructions that run in sequence and branches that are not taken leave the register alone. Software can read the register at any time and can load all 64 bits in one cycle.

When an interrupt is accepted, the block takes a snapshot of the register. The snapshot includes any taken-branch update that completes in the same cycle. The block then stores the snapshot as one doubleword to real address 0x110 through a valid/ready store port. While that store is outstanding, the block stalls further interrupts. The snapshot is held stable on the port until it is accepted.

Top module: `branch_event_tracker`

## Requirements
- R1: After a synchronous active-low reset, `bea_value` is zero, `st_valid` is 0 and `irq_ready` is 1.
- R2: When `ret_valid`, `ret_taken` are 1 and `ret_via_exec` is 0 (and `sw_load` is 0), `bea_value` equals `ret_addr` one cycle later.
- R3: When `ret_valid`, `ret_taken` and `ret_via_exec` are all 1 (and `sw_load` is 0), `bea_value` equals `ret_exec_addr` one cycle later, not `ret_addr`.
- R4: A retire with `ret_taken` 0, or any cycle with `ret_valid` 0 and `sw_load` 0, leaves `bea_value` unchanged.
- R5: `sw_load` writes all 64 bits of `sw_data` into the register in one cycle, and it takes priority over a retire update in the same cycle.
- R6: An interrupt is accepted in a cycle where `irq_req` and `irq_ready` are both 1. From the next cycle, `st_valid` is 1 and `st_addr` is 0x110. `st_data` holds the register value including any update from the same cycle. `st_data` is big-endian: bits 63:56 are the byte at 0x110, and bit 63 is architectural bit 0.
- R7: While `st_valid` is 1 and `st_ready` is 0, `st_valid`, `st_addr` and `st_data` stay unchanged, even if the register is updated meanwhile.
- R8: While a store is outstanding, `irq_ready` is 0 and `irq_req` is ignored. One cycle after `st_valid` and `st_ready` are both 1, `st_valid` is 0 and `irq_ready` is 1, and no second store is issued for interrupts raised while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ret_valid | input | 1 | An instruction completes this cycle |
| ret_taken | input | 1 | The completing instruction is a taken branch |
| ret_via_exec | input | 1 | The completing instruction ran as target of an execute-type instruction |
| ret_addr | input | 64 | Address of the completing instruction |
| ret_exec_addr | input | 64 | Address of the executor instruction |
| sw_load | input | 1 | Software load strobe |
| sw_data | input | 64 | Software load value |
| bea_value | output | 64 | Current register value for software reads |
| irq_req | input | 1 | Interrupt request |
| irq_ready | output | 1 | Interrupt can be accepted this cycle |
| st_valid | output | 1 | Doubleword store request |
| st_ready | input | 1 | Store accepted by memory side |
| st_addr | output | 64 | Store real address |
| st_data | output | 64 | Store doubleword, big-endian |

## Verification
The bench sweeps all sixteen combinations of retire valid, taken, execute-target and software load, with distinct addresses on each of the three sources. This shows which source reaches the register and which combinations leave it untouched. The interrupt path is run with store-ready delays of zero to three cycles. Each delay is run with and without a taken branch in the accepting cycle, which separates a snapshot taken before the update from one taken after it. During each wait the bench raises more interrupts and retires further branches, to show that the port data stays frozen and that no extra store appears.

// File: rtl/bea_pkg.sv
// Shared types for the branch event address tracker.
// Assumes: nothing beyond IEEE 1800-2017.
package bea_pkg;
    typedef enum logic {
        DUMP_IDLE = 1'b0,
        DUMP_SEND = 1'b1
    } dump_state_e;
endpackage

// File: rtl/bea_capture.sv
// Holds the breaking-event address register and computes its next value.
// Assumes: retire signals are only meaningful at instruction completion;
// a software load wins over a retire update in the same cycle.
module bea_capture #(
    parameter int unsigned ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ret_valid,
    input  logic              ret_taken,
    input  logic              ret_via_exec,
    input  logic [ADDR_W-1:0] ret_addr,
    input  logic [ADDR_W-1:0] ret_exec_addr,
    input  logic              sw_load,
    input  logic [ADDR_W-1:0] sw_data,
    output logic [ADDR_W-1:0] bea_q,
    output logic [ADDR_W-1:0] bea_next
);
    logic branch_done;

    // Select the value the register takes at the next edge.
    always_comb begin
        branch_done = ret_valid && ret_taken;
        bea_next    = bea_q;
        if (sw_load) begin
            bea_next = sw_data;
        end else if (branch_done) begin
            bea_next = ret_via_exec ? ret_exec_addr : ret_addr;
        end
    end

    // Register the address, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bea_q <= '0;
        end else begin
            bea_q <= bea_next;
        end
    end

    AST_PLAIN_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && ret_taken && !ret_via_exec && !sw_load) |=> (bea_q == $past(ret_addr))); // R2
    AST_EXEC_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && ret_taken && ret_via_exec && !sw_load) |=> (bea_q == $past(ret_exec_addr))); // R3
    AST_SEQ_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_load && !(ret_valid && ret_taken)) |=> $stable(bea_q)); // R4
    AST_SW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        sw_load |=> (bea_q == $past(sw_data))); // R5
endmodule

// File: rtl/bea_dump.sv
// Stores a snapshot of the address register to a fixed real address when an
// interrupt is accepted, through a valid/ready store port.
// Assumes: the memory side may hold st_ready low for any number of cycles.
module bea_dump
    import bea_pkg::*;
#(
    parameter int unsigned       ADDR_W    = 64,
    parameter logic [ADDR_W-1:0] DUMP_ADDR = 64'h110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_req,
    input  logic [ADDR_W-1:0] snap_in,
    output logic              irq_ready,
    output logic              st_valid,
    output logic [ADDR_W-1:0] st_addr,
    output logic [ADDR_W-1:0] st_data,
    input  logic              st_ready
);
    dump_state_e state_q;
    logic [ADDR_W-1:0] data_q;
    logic accept;

    // Interrupts are taken only while no store is pending.
    always_comb begin
        irq_ready = (state_q == DUMP_IDLE);
        accept    = irq_req && irq_ready;
        st_valid  = (state_q == DUMP_SEND);
        st_addr   = DUMP_ADDR;
        st_data   = data_q;
    end

    // Sequence the store: capture on accept, release on handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DUMP_IDLE;
            data_q  <= '0;
        end else begin
            case (state_q)
                DUMP_IDLE: if (accept) begin
                    state_q <= DUMP_SEND;
                    data_q  <= snap_in;
                end
                DUMP_SEND: if (st_ready) begin
                    state_q <= DUMP_IDLE;
                end
                default: state_q <= DUMP_IDLE;
            endcase
        end
    end

    AST_TAKE_SNAPSHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_ready) |=> (st_valid && st_data == $past(snap_in))); // R6
    AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !st_ready) |=> st_valid); // R7
    AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !st_ready) |=> ($stable(st_data) && $stable(st_addr))); // R7
    AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_ready) |=> (!st_valid && irq_ready)); // R8
endmodule

// File: rtl/branch_event_tracker.sv
// Top of the branch event address tracker: the capture register plus the
// interrupt-time doubleword store.
// Assumes: one retire per cycle; st_data is big-endian (bits 63:56 = byte at
// the lowest address, bit 63 = architectural bit 0).
module branch_event_tracker #(
    parameter int unsigned       ADDR_W    = 64,
    parameter logic [ADDR_W-1:0] DUMP_ADDR = 64'h110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ret_valid,
    input  logic              ret_taken,
    input  logic              ret_via_exec,
    input  logic [ADDR_W-1:0] ret_addr,
    input  logic [ADDR_W-1:0] ret_exec_addr,
    input  logic              sw_load,
    input  logic [ADDR_W-1:0] sw_data,
    output logic [ADDR_W-1:0] bea_value,
    input  logic              irq_req,
    output logic              irq_ready,
    output logic              st_valid,
    input  logic              st_ready,
    output logic [ADDR_W-1:0] st_addr,
    output logic [ADDR_W-1:0] st_data
);
    logic [ADDR_W-1:0] bea_next;

    bea_capture #(.ADDR_W(ADDR_W)) u_capture (
        .clk          (clk),
        .rst_n        (rst_n),
        .ret_valid    (ret_valid),
        .ret_taken    (ret_taken),
        .ret_via_exec (ret_via_exec),
        .ret_addr     (ret_addr),
        .ret_exec_addr(ret_exec_addr),
        .sw_load      (sw_load),
        .sw_data      (sw_data),
        .bea_q        (bea_value),
        .bea_next     (bea_next)
    );

    bea_dump #(.ADDR_W(ADDR_W), .DUMP_ADDR(DUMP_ADDR)) u_dump (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_req  (irq_req),
        .snap_in  (bea_next),
        .irq_ready(irq_ready),
        .st_valid (st_valid),
        .st_addr  (st_addr),
        .st_data  (st_data),
        .st_ready (st_ready)
    );

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (!st_valid && irq_ready && bea_value == '0)); // R1
    AST_BUSY_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |-> !irq_ready); // R8
endmodule

// File: tb/branch_event_tracker_tb.sv
// Self-checking bench: sweeps retire flag combinations and interrupt store
// handshakes with several ready delays.
module branch_event_tracker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ret_valid = 1'b0, ret_taken = 1'b0, ret_via_exec = 1'b0;
    logic [63:0] ret_addr = '0, ret_exec_addr = '0;
    logic        sw_load = 1'b0;
    logic [63:0] sw_data = '0;
    logic [63:0] bea_value;
    logic        irq_req = 1'b0, irq_ready;
    logic        st_valid, st_ready = 1'b0;
    logic [63:0] st_addr, st_data;

    int n_chk = 0;
    int n_bad = 0;
    logic [63:0] exp_bea = '0;
    logic [63:0] exp_snap;

    always #5 clk = ~clk;

    branch_event_tracker u_dut (
        .clk(clk), .rst_n(rst_n),
        .ret_valid(ret_valid), .ret_taken(ret_taken), .ret_via_exec(ret_via_exec),
        .ret_addr(ret_addr), .ret_exec_addr(ret_exec_addr),
        .sw_load(sw_load), .sw_data(sw_data), .bea_value(bea_value),
        .irq_req(irq_req), .irq_ready(irq_ready),
        .st_valid(st_valid), .st_ready(st_ready),
        .st_addr(st_addr), .st_data(st_data)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Advance one clock; inputs change and outputs are sampled at negedge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Bench model of the register update for the current inputs.
    function automatic logic [63:0] model_next(input logic [63:0] cur);
        if (sw_load) return sw_data;
        if (ret_valid && ret_taken) return ret_via_exec ? ret_exec_addr : ret_addr;
        return cur;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        step(); step();
        // R1: reset state
        check("R1 bea", bea_value, 64'h0);
        check("R1 st_valid", {63'b0, st_valid}, 64'h0);
        check("R1 irq_ready", {63'b0, irq_ready}, 64'h1);
        rst_n = 1'b1;

        // R2 R3 R4 R5: all combinations of valid/taken/exec/load, two rounds
        for (int round = 0; round < 2; round++) begin
            for (int c = 0; c < 16; c++) begin
                ret_valid     = c[0];
                ret_taken     = c[1];
                ret_via_exec  = c[2];
                sw_load       = c[3];
                ret_addr      = 64'hA000_0000_0000_0000 + 64'(c * 16 + round * 4096);
                ret_exec_addr = 64'h00B0_0000_0000_0000 + 64'(c * 32 + round * 8192);
                sw_data       = 64'hC3C3_0000_5A5A_0000 ^ 64'(c * 257 + round);
                exp_bea = model_next(exp_bea);
                step();
                if (c[3])
                    check("R5 sw load", bea_value, exp_bea);
                else if (c[0] && c[1] && c[2])
                    check("R3 exec target", bea_value, exp_bea);
                else if (c[0] && c[1])
                    check("R2 taken branch", bea_value, exp_bea);
                else
                    check("R4 unchanged", bea_value, exp_bea);
            end
        end
        ret_valid = 0; ret_taken = 0; ret_via_exec = 0; sw_load = 0;

        // R6 R7 R8: interrupt stores with ready delays 0..3
        for (int d = 0; d < 4; d++) begin
            for (int wb = 0; wb < 2; wb++) begin
                ret_valid     = wb[0];
                ret_taken     = wb[0];
                ret_via_exec  = d[0];
                ret_addr      = 64'h1111_2222_3333_0000 + 64'(d * 8 + wb);
                ret_exec_addr = 64'h4444_5555_6666_0000 + 64'(d * 8 + wb);
                irq_req = 1'b1;
                exp_bea  = model_next(exp_bea);
                exp_snap = exp_bea;
                step();
                ret_valid = 0; ret_taken = 0;
                check("R6 st_valid", {63'b0, st_valid}, 64'h1);
                check("R6 st_addr", st_addr, 64'h110);
                check("R6 st_data", st_data, exp_snap);
                check("R6 byte at 0x110", {56'b0, st_data[63:56]}, {56'b0, exp_snap[63:56]});
                // irq_req stays high while busy and must be ignored
                for (int w = 0; w < d; w++) begin
                    ret_valid = 1'b1; ret_taken = 1'b1; ret_via_exec = 1'b0;
                    ret_addr  = 64'hDEAD_0000_0000_0000 + 64'(w + d * 16);
                    exp_bea   = model_next(exp_bea);
                    step();
                    check("R7 hold valid", {63'b0, st_valid}, 64'h1);
                    check("R7 hold data", st_data, exp_snap);
                    check("R7 hold addr", st_addr, 64'h110);
                    check("R8 stalled", {63'b0, irq_ready}, 64'h0);
                end
                ret_valid = 0; ret_taken = 0;
                irq_req  = 1'b0;
                st_ready = 1'b1;
                step();
                st_ready = 1'b0;
                check("R8 released", {63'b0, st_valid}, 64'h0);
                check("R8 ready again", {63'b0, irq_ready}, 64'h1);
                step();
                check("R8 no extra store", {63'b0, st_valid}, 64'h0);
                check("R4 bea after dump", bea_value, exp_bea);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule